// File: doc/BRIEF.md
# Non-Audio Burst Sync Detector

This block watches the 16-bit words recovered from a digital audio receiver, one word per subframe. It looks for the six-word, 96-bit preamble that marks a compressed, non-PCM payload. The preamble is four zero words followed by 0xF872 and then 0x4E1F. When the last of the six words arrives, an internal detect flag goes high. The flag stays high while further preambles keep arriving within a window of frames. If no further preamble arrives within the window, the flag drops.

The reported non-audio indicator is the detect flag ORed with the non-audio bit taken from the received channel status. The block only observes the stream. It does not touch the audio samples, which continue down the normal audio path unchanged.

Top module: `nonpcm_sync_detect`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the sequence state and the frame counter. After reset `detect_flag` is 0 and `nonaudio_out` equals `cs_nonaudio_bit`.
- R2: The preamble is detected when the last six words accepted with `word_valid` high are, in order, 0x0000, 0x0000, 0x0000, 0x0000, 0xF872 and 0x4E1F. `detect_flag` is 1 from the clock edge that accepts the final word.
- R3: A cycle with `word_valid` low neither advances nor breaks the sequence.
- R4: A wrong word restarts the search. A wrong word of value 0x0000 is kept as a possible start of the preamble, together with any zero words just before it. As a result, detection follows exactly the rule in R2, whatever words came earlier.
- R5: After a detection with no later detection, `detect_flag` stays 1 through the first 4095 frame-start strobes (`TIMEOUT_FRAMES`-1). It falls to 0 at the clock edge that accepts the 4096th strobe.
- R6: Each new detection restarts the full window of `TIMEOUT_FRAMES` frame-start strobes.
- R7: A detection and a frame-start strobe in the same cycle leave a full window, so the frame-start strobe is not counted.
- R8: `nonaudio_out` is the combinational OR of `detect_flag` and `cs_nonaudio_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Qualifies `word_in` for one cycle |
| word_in | input | 16 | Received audio word |
| frame_start | input | 1 | One-cycle strobe at each frame start |
| cs_nonaudio_bit | input | 1 | Received channel-status non-audio bit |
| detect_flag | output | 1 | Preamble seen within the window |
| nonaudio_out | output | 1 | Combined non-audio indicator |

## Verification
The hardest situations to reach from the ports are the edges of the frame window. The window must be driven to exactly its last strobe, and a new detection must land on the same cycle as a frame-start strobe. The stimulus sends a preamble and then issues exactly 4096 frame-start strobes. It then places a retrigger partway into a window, and separately completes a preamble on a frame-start cycle. Near-miss streams cover the restart cases: an extra leading zero, a zero in place of 0x4E1F, a wrong middle word, and invalid gaps inside a preamble. A reference model keeps the last six accepted words and a plain counter, and it is compared with the outputs on every cycle.

// File: rtl/nonpcm_sync_detect.sv
module nonpcm_sync_detect #(
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        word_valid,
  input  logic [15:0] word_in,
  input  logic        frame_start,
  input  logic        cs_nonaudio_bit,
  output logic        detect_flag,
  output logic        nonaudio_out
);
  localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);

  logic [2:0]       idx;
  logic [CNT_W-1:0] cnt;

  function automatic logic [15:0] want(input logic [2:0] i);
    case (i)
      3'd4:    want = 16'hF872;
      3'd5:    want = 16'h4E1F;
      default: want = 16'h0000;
    endcase
  endfunction

  wire hit  = word_valid && (word_in == want(idx));
  wire full = hit && (idx == 3'd5);

  always_ff @(posedge clk) begin
    if (rst)
      idx <= 3'd0;
    else if (word_valid) begin
      if (full)
        idx <= 3'd0;
      else if (hit)
        idx <= idx + 3'd1;
      else if (word_in == 16'h0000)
        idx <= (idx == 3'd4) ? 3'd4 : 3'd1;
      else
        idx <= 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (full)
      cnt <= CNT_W'(TIMEOUT_FRAMES);
    else if (frame_start && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign detect_flag  = (cnt != '0);
  assign nonaudio_out = detect_flag | cs_nonaudio_bit;
endmodule

module nonpcm_sync_detect_chk (
  input logic        clk,
  input logic        rst,
  input logic        word_valid,
  input logic [15:0] word_in,
  input logic        frame_start,
  input logic        cs_nonaudio_bit,
  input logic        detect_flag,
  input logic        nonaudio_out
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !detect_flag);

  // R2
  rise_on_last_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(detect_flag) |-> ($past(word_valid) && $past(word_in) == 16'h4E1F));

  // R5
  fall_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(detect_flag) |-> ($past(frame_start) || $past(rst)));

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && !frame_start) |=> $stable(detect_flag));

  // R8
  indicator_or_chk: assert property (@(posedge clk)
    (detect_flag || cs_nonaudio_bit) |-> nonaudio_out);
endmodule

bind nonpcm_sync_detect nonpcm_sync_detect_chk u_chk (.*);

// File: tb/nonpcm_sync_detect_tb.sv
module nonpcm_sync_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 4096;

  logic clk = 0, rst = 1, word_valid = 0, frame_start = 0, cs_bit = 0;
  logic [15:0] word_in = 0;
  logic detect_flag, nonaudio_out;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  int hist[$];
  int mcnt = 0;
  int pat[6] = '{0, 0, 0, 0, 'hF872, 'h4E1F};

  always #(CLK_PERIOD/2) clk = ~clk;

  nonpcm_sync_detect #(.TIMEOUT_FRAMES(TMO)) u_dut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
    .frame_start(frame_start), .cs_nonaudio_bit(cs_bit),
    .detect_flag(detect_flag), .nonaudio_out(nonaudio_out));

  always @(posedge clk) begin
    bit m;
    m = 0;
    if (rst) begin
      hist.delete();
      mcnt = 0;
    end else begin
      if (word_valid) begin
        hist.push_back(int'(word_in));
        if (hist.size() > 6) void'(hist.pop_front());
        if (hist.size() == 6) begin
          m = 1;
          for (int i = 0; i < 6; i++) if (hist[i] != pat[i]) m = 0;
          if (m) hist.delete();
        end
      end
      if (m) mcnt = TMO;
      else if (frame_start && mcnt > 0) mcnt = mcnt - 1;
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] w, input logic fs);
    word_valid = v; word_in = w; frame_start = fs;
    @(posedge clk);
    @(negedge clk);
    check(detect_flag, mcnt > 0, "detect_flag");
    check(nonaudio_out, (mcnt > 0) | cs_bit, "nonaudio_out");
  endtask

  task automatic send(input int w);
    step(1, 16'(w), 0);
  endtask

  task automatic preamble();
    for (int i = 0; i < 6; i++) send(pat[i]);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) step(0, 16'h0, 1);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1;
    tag = "R1"; step(0, 0, 1);
    check(detect_flag, 0, "reset flag");
    rst = 0;
    step(0, 0, 0);

    tag = "R2"; preamble();
    check(detect_flag, 1, "after preamble");

    tag = "R5"; frames(TMO - 1);
    check(detect_flag, 1, "after 4095 frames");
    frames(1);
    check(detect_flag, 0, "after 4096 frames");

    tag = "R3";
    send(0); step(0, 16'h1234, 1); send(0); step(0, 16'hF872, 0);
    send(0); send(0); step(0, 16'h4E1F, 0); send('hF872); send('h4E1F);
    check(detect_flag, 1, "gapped preamble");
    rst = 1; step(0, 0, 0); rst = 0; step(0, 0, 0);

    tag = "R4";
    send(0); send(0); send(0); send(0); send('h1111); send('hF872); send('h4E1F);
    check(detect_flag, 0, "wrong middle word");
    send(0); preamble();
    check(detect_flag, 1, "extra leading zero");
    rst = 1; step(0, 0, 0); rst = 0; step(0, 0, 0);
    send(0); send(0); send(0); send(0); send('hF872); send(0);
    send(0); send(0); send(0); send('hF872); send('h4E1F);
    check(detect_flag, 1, "zero in place of last word");
    send('hF872); send(0); send(0); send(0); send('hF872); send('h4E1F);
    check(detect_flag, 1, "three zeros then tail, no new match");

    tag = "R6";
    rst = 1; step(0, 0, 0); rst = 0; step(0, 0, 0);
    preamble(); frames(2000); preamble(); frames(3000);
    check(detect_flag, 1, "retriggered window");
    frames(TMO - 3000);
    check(detect_flag, 0, "retriggered expiry");

    tag = "R7";
    preamble(); frames(100);
    for (int i = 0; i < 5; i++) send(pat[i]);
    step(1, 16'h4E1F, 1);
    frames(TMO - 1);
    check(detect_flag, 1, "match with strobe");
    frames(1);
    check(detect_flag, 0, "match with strobe expiry");

    tag = "R8";
    cs_bit = 1; step(0, 0, 0);
    check(nonaudio_out, 1, "cs only");
    cs_bit = 0; step(0, 0, 0);
    check(nonaudio_out, 0, "neither");
    preamble(); cs_bit = 1; step(0, 0, 0); cs_bit = 0; step(0, 0, 0);
    check(nonaudio_out, 1, "flag only");

    done = 1;
    finish_up();
  end
endmodule